// File: doc/BRIEF.md
# Serial Link Request Encoder

This block sits on the link side of a link-to-physical-layer interface and turns register-access commands into frames on a single request wire. A command arrives on a valid/ready port as either a register write (register number plus one data byte) or an arbitration-acceleration switch (one enable bit). The block builds the frame, which is a start bit, a 3-bit type code, the payload and a stop bit. It then shifts the frame out one bit per clock.

The same block gates bus-arbitration requests that other link logic raises. It watches the 2-bit control code the physical layer drives. It reports when an arbitration request may start: the interface has been idle for at least one full clock, no frame is on the wire, and no earlier arbitration request is still outstanding. It records an issued request as outstanding until the physical layer reports it lost or won. Register-access frames are never held back by an outstanding arbitration request.

The shifter is a three-state machine:
- `SH_IDLE` moves to `SH_SEND` when a command is accepted.
- `SH_SEND` moves to `SH_STOP` when the bit being loaded is the stop bit.
- `SH_STOP` always returns to `SH_IDLE`.

The arbitration gate is a two-state machine:
- `ARB_FREE` moves to `ARB_HELD` when a request is issued while it is allowed.
- `ARB_HELD` moves back to `ARB_FREE` on lost or won.

Top module: `req_line_serializer`

## Requirements
- R1: A register-write command (cmd_kind = 0) produces a 17-bit frame. Bit 0 appears on req_line in the clock after acceptance, and bits follow one per clock in increasing index. Bit 0 is 1. Bits 1..3 are 1,0,1. Bits 4..7 carry cmd_addr, most significant bit first. Bits 8..15 carry cmd_data, most significant bit first. Bit 16 is 0.
- R2: An acceleration command (cmd_kind = 1) produces a 6-bit frame, driven with the same timing as R1. The bits are 1, then 1,1,0, then cmd_accel_on (1 means enable), then 0.
- R3: cmd_ready is low from the clock after acceptance through the clock that drives the stop bit. It is high again in the next clock, so a command offered in that clock starts its frame right away.
- R4: req_line is low whenever no frame is being shifted. A command offered while cmd_ready is low is ignored and does not alter the frame in flight.
- R5: arb_allowed is high only if ctl_code is idle (00) in the current clock and was also idle in the previous clock.
- R6: arb_allowed is low while an arbitration request is outstanding and while a frame occupies req_line.
- R7: arb_issue sampled while arb_allowed is high makes arb_outstanding high from the next clock. arb_issue at any other time is ignored.
- R8: arb_lost or arb_won while a request is outstanding clears arb_outstanding in the next clock and re-opens arbitration.
- R9: Register-access commands are accepted and framed normally while an arbitration request is outstanding and whatever the control code is. They leave the outstanding request in place.
- R10: A synchronous reset, including one during a frame, returns the block to idle in the next clock. After it, req_line is low, cmd_ready is high and arb_outstanding is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command accepted in this clock when valid |
| cmd_kind | input | 1 | 0 register write, 1 acceleration control |
| cmd_addr | input | ADDR_W (4) | Register number for a write |
| cmd_data | input | DATA_W (8) | Data byte for a write |
| cmd_accel_on | input | 1 | Acceleration enable value |
| ctl_code | input | CTL_W (2) | Interface control code from the physical layer, 00 = idle |
| arb_issue | input | 1 | Arbitration request being started by link logic |
| arb_lost | input | 1 | Outstanding arbitration request lost |
| arb_won | input | 1 | Outstanding arbitration request won |
| arb_allowed | output | 1 | An arbitration request may start now |
| arb_outstanding | output | 1 | An arbitration request awaits its outcome |
| req_line | output | 1 | Serial request line |

## Verification
The bench builds the block with its default parameters: a 4-bit register number, an 8-bit data byte and a 2-bit control code. At these sizes the longest frame is 17 bits. All-zero, all-one and alternating address/data patterns can therefore place every payload bit position on the wire and compare it against an expected frame computed bit by bit. These sizes keep the whole frame length, and the back-to-back restart at the exact clock cmd_ready returns, short enough to check one clock at a time. They also let the bench step the control code through receive, status and idle cycle by cycle to test the one-clock idle rule and the single-outstanding-request rule.

// File: rtl/rls_pkg.sv
package rls_pkg;

    localparam int TYPE_W = 3;
    localparam logic [TYPE_W-1:0] TYPE_REG_WRITE = 3'b101;
    localparam logic [TYPE_W-1:0] TYPE_ACCEL     = 3'b110;

    // frame of an acceleration command: start, type, control, stop
    localparam int ACCEL_LEN = 1 + TYPE_W + 1 + 1;

    typedef enum logic {
        CMD_REG_WRITE = 1'b0,
        CMD_ACCEL     = 1'b1
    } cmd_kind_e;

    typedef enum logic [1:0] {
        SH_IDLE = 2'd0,
        SH_SEND = 2'd1,
        SH_STOP = 2'd2
    } sh_state_e;

    typedef enum logic {
        ARB_FREE = 1'b0,
        ARB_HELD = 1'b1
    } arb_state_e;

    function automatic int reg_write_len(input int addr_w, input int data_w);
        return 1 + TYPE_W + addr_w + data_w + 1;
    endfunction

endpackage

// File: rtl/rls_frame_build.sv
module rls_frame_build
    import rls_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter int DATA_W  = 8,
    parameter int FRAME_W = reg_write_len(ADDR_W, DATA_W),
    parameter int CNT_W   = $clog2(FRAME_W + 1)
) (
    input  logic               kind,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  data,
    input  logic               accel_on,
    output logic [FRAME_W-1:0] frame,   // bit 0 of the frame sits at the MSB
    output logic [CNT_W-1:0]   frame_len
);

    localparam int PAD_W = FRAME_W - ACCEL_LEN;

    logic [FRAME_W-1:0] write_frame;
    logic [FRAME_W-1:0] accel_frame;

    assign write_frame = {1'b1, TYPE_REG_WRITE, addr, data, 1'b0};

    generate
        if (PAD_W > 0) begin : g_accel_pad
            assign accel_frame = {1'b1, TYPE_ACCEL, accel_on, 1'b0, {PAD_W{1'b0}}};
        end else begin : g_accel_nopad
            assign accel_frame = {1'b1, TYPE_ACCEL, accel_on, 1'b0};
        end
    endgenerate

    always_comb begin
        frame     = '0;
        frame_len = '0;
        unique case (cmd_kind_e'(kind))
            CMD_REG_WRITE: begin
                frame     = write_frame;
                frame_len = CNT_W'(FRAME_W);
            end
            CMD_ACCEL: begin
                frame     = accel_frame;
                frame_len = CNT_W'(ACCEL_LEN);
            end
            default: begin
                frame     = '0;
                frame_len = '0;
            end
        endcase
    end

endmodule

// File: rtl/rls_shifter.sv
module rls_shifter
    import rls_pkg::*;
#(
    parameter int FRAME_W = 17,
    parameter int CNT_W   = $clog2(FRAME_W + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load_valid,
    input  logic [FRAME_W-1:0] load_frame,
    input  logic [CNT_W-1:0]   load_len,
    output logic               load_ready,
    output logic               line_busy,
    output logic               line_out
);

    localparam int SH_W = FRAME_W - 1;

    sh_state_e        state_q;
    sh_state_e        state_d;
    logic [CNT_W-1:0] left_q;     // bits still to drive after the current one
    logic [SH_W-1:0]  shreg_q;
    logic             line_q;
    logic             accept;

    assign accept = load_valid && (state_q == SH_IDLE);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SH_IDLE: if (accept)                  state_d = SH_SEND;
            SH_SEND: if (left_q == CNT_W'(1))     state_d = SH_STOP;
            SH_STOP:                              state_d = SH_IDLE;
            default:                              state_d = SH_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= SH_IDLE;
        else     state_q <= state_d;
    end

    // shift datapath
    always_ff @(posedge clk) begin
        if (rst) begin
            line_q  <= 1'b0;
            left_q  <= '0;
            shreg_q <= '0;
        end else begin
            unique case (state_q)
                SH_IDLE: begin
                    if (accept) begin
                        line_q  <= load_frame[FRAME_W-1];
                        shreg_q <= load_frame[FRAME_W-2:0];
                        left_q  <= load_len - CNT_W'(1);
                    end else begin
                        line_q  <= 1'b0;
                    end
                end
                SH_SEND: begin
                    line_q  <= shreg_q[SH_W-1];
                    shreg_q <= {shreg_q[SH_W-2:0], 1'b0};
                    left_q  <= left_q - CNT_W'(1);
                end
                SH_STOP: begin
                    line_q  <= 1'b0;
                    left_q  <= '0;
                end
                default: line_q <= 1'b0;
            endcase
        end
    end

    // outputs
    always_comb begin
        load_ready = (state_q == SH_IDLE);
        line_busy  = (state_q != SH_IDLE);
        line_out   = line_q;
    end

endmodule

// File: rtl/rls_arb_gate.sv
module rls_arb_gate
    import rls_pkg::*;
#(
    parameter int CTL_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CTL_W-1:0] ctl,
    input  logic             frame_busy,
    input  logic             issue,
    input  logic             lost,
    input  logic             won,
    output logic             allowed,
    output logic             outstanding
);

    localparam logic [CTL_W-1:0] CTL_IDLE = '0;

    arb_state_e state_q;
    arb_state_e state_d;
    logic       idle_now;
    logic       idle_q;     // control code was idle in the previous clock
    logic       open_c;

    assign idle_now = (ctl == CTL_IDLE);
    assign open_c   = idle_now && idle_q && !frame_busy && (state_q == ARB_FREE);

    always_ff @(posedge clk) begin
        if (rst) idle_q <= 1'b0;
        else     idle_q <= idle_now;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ARB_FREE: if (issue && open_c) state_d = ARB_HELD;
            ARB_HELD: if (lost || won)     state_d = ARB_FREE;
            default:                       state_d = ARB_FREE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ARB_FREE;
        else     state_q <= state_d;
    end

    // outputs
    always_comb begin
        allowed     = open_c;
        outstanding = (state_q == ARB_HELD);
    end

endmodule

// File: rtl/req_line_serializer.sv
module req_line_serializer
    import rls_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8,
    parameter int CTL_W  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic              cmd_kind,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_data,
    input  logic              cmd_accel_on,
    input  logic [CTL_W-1:0]  ctl_code,
    input  logic              arb_issue,
    input  logic              arb_lost,
    input  logic              arb_won,
    output logic              arb_allowed,
    output logic              arb_outstanding,
    output logic              req_line
);

    localparam int FRAME_W = reg_write_len(ADDR_W, DATA_W);
    localparam int CNT_W   = $clog2(FRAME_W + 1);

    logic [FRAME_W-1:0] frame;
    logic [CNT_W-1:0]   frame_len;
    logic               busy;

    rls_frame_build #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .FRAME_W (FRAME_W),
        .CNT_W   (CNT_W)
    ) i_build (
        .kind      (cmd_kind),
        .addr      (cmd_addr),
        .data      (cmd_data),
        .accel_on  (cmd_accel_on),
        .frame     (frame),
        .frame_len (frame_len)
    );

    rls_shifter #(
        .FRAME_W (FRAME_W),
        .CNT_W   (CNT_W)
    ) i_shift (
        .clk        (clk),
        .rst        (rst),
        .load_valid (cmd_valid),
        .load_frame (frame),
        .load_len   (frame_len),
        .load_ready (cmd_ready),
        .line_busy  (busy),
        .line_out   (req_line)
    );

    rls_arb_gate #(
        .CTL_W (CTL_W)
    ) i_gate (
        .clk         (clk),
        .rst         (rst),
        .ctl         (ctl_code),
        .frame_busy  (busy),
        .issue       (arb_issue),
        .lost        (arb_lost),
        .won         (arb_won),
        .allowed     (arb_allowed),
        .outstanding (arb_outstanding)
    );

endmodule

// File: rtl/req_line_serializer_checker.sv
module req_line_serializer_checker #(
    parameter int CTL_W = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             cmd_valid,
    input logic             cmd_ready,
    input logic             cmd_kind,
    input logic             cmd_accel_on,
    input logic [CTL_W-1:0] ctl_code,
    input logic             arb_issue,
    input logic             arb_lost,
    input logic             arb_won,
    input logic             arb_allowed,
    input logic             arb_outstanding,
    input logic             req_line
);

    assert_start_bit_R1: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_ready) |=> req_line);

    assert_accel_frame_R2: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_ready && cmd_kind) |=>
            req_line ##1 req_line ##1 req_line ##1 !req_line
            ##1 (req_line == $past(cmd_accel_on, 5)) ##1 !req_line);

    assert_line_busy_R3: assert property (@(posedge clk) disable iff (rst)
        req_line |-> !cmd_ready);

    assert_allowed_idle_R5: assert property (@(posedge clk) disable iff (rst)
        arb_allowed |-> (ctl_code == '0) && ($past(ctl_code) == '0));

    assert_allowed_exclusive_R6: assert property (@(posedge clk) disable iff (rst)
        arb_allowed |-> (!arb_outstanding && cmd_ready));

    assert_outstanding_set_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(arb_outstanding) |-> $past(arb_issue && arb_allowed));

    assert_outstanding_clear_R8: assert property (@(posedge clk) disable iff (rst)
        (arb_outstanding && (arb_lost || arb_won)) |=> !arb_outstanding);

    assert_reset_state_R10: assert property (@(posedge clk)
        rst |=> (cmd_ready && !req_line && !arb_outstanding));

endmodule

bind req_line_serializer req_line_serializer_checker #(
    .CTL_W (CTL_W)
) i_chk (
    .clk             (clk),
    .rst             (rst),
    .cmd_valid       (cmd_valid),
    .cmd_ready       (cmd_ready),
    .cmd_kind        (cmd_kind),
    .cmd_accel_on    (cmd_accel_on),
    .ctl_code        (ctl_code),
    .arb_issue       (arb_issue),
    .arb_lost        (arb_lost),
    .arb_won         (arb_won),
    .arb_allowed     (arb_allowed),
    .arb_outstanding (arb_outstanding),
    .req_line        (req_line)
);

// File: tb/test_req_line_serializer.sv
`timescale 1ns/1ps
module test_req_line_serializer;

    localparam int AW     = 4;
    localparam int DW     = 8;
    localparam int WR_LEN = 1 + 3 + AW + DW + 1;
    localparam int AC_LEN = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cmd_valid = 1'b0;
    logic          cmd_kind = 1'b0;
    logic [AW-1:0] cmd_addr = '0;
    logic [DW-1:0] cmd_data = '0;
    logic          cmd_accel_on = 1'b0;
    logic [1:0]    ctl_code = 2'b10;
    logic          arb_issue = 1'b0;
    logic          arb_lost = 1'b0;
    logic          arb_won = 1'b0;
    logic          cmd_ready;
    logic          arb_allowed;
    logic          arb_outstanding;
    logic          req_line;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    req_line_serializer i_req_line_serializer (
        .clk             (clk),
        .rst             (rst),
        .cmd_valid       (cmd_valid),
        .cmd_ready       (cmd_ready),
        .cmd_kind        (cmd_kind),
        .cmd_addr        (cmd_addr),
        .cmd_data        (cmd_data),
        .cmd_accel_on    (cmd_accel_on),
        .ctl_code        (ctl_code),
        .arb_issue       (arb_issue),
        .arb_lost        (arb_lost),
        .arb_won         (arb_won),
        .arb_allowed     (arb_allowed),
        .arb_outstanding (arb_outstanding),
        .req_line        (req_line)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [WR_LEN-1:0] exp_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        logic [WR_LEN-1:0] e;
        e = '0;
        e[0] = 1'b1; e[1] = 1'b1; e[2] = 1'b0; e[3] = 1'b1;
        for (int i = 0; i < AW; i++) e[4+i] = a[AW-1-i];
        for (int j = 0; j < DW; j++) e[4+AW+j] = d[DW-1-j];
        e[WR_LEN-1] = 1'b0;
        return e;
    endfunction

    function automatic logic [WR_LEN-1:0] exp_accel(input logic on);
        logic [WR_LEN-1:0] e;
        e = '0;
        e[0] = 1'b1; e[1] = 1'b1; e[2] = 1'b1; e[3] = 1'b0; e[4] = on; e[5] = 1'b0;
        return e;
    endfunction

    // offer one command, record the line bit by bit, check ready around the frame
    task automatic capture(input logic kind, input logic [AW-1:0] a, input logic [DW-1:0] d,
                           input logic on, input int len, output logic [WR_LEN-1:0] got);
        bit low_all;
        @(negedge clk);
        cmd_kind = kind; cmd_addr = a; cmd_data = d; cmd_accel_on = on; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        got = '0;
        low_all = 1'b1;
        for (int i = 0; i < len; i++) begin
            got[i] = req_line;
            if (cmd_ready) low_all = 1'b0;
            @(negedge clk);
        end
        check(low_all, "R3 ready low during frame", int'(low_all), 1);
        check(cmd_ready == 1'b1, "R3 ready back after stop bit", int'(cmd_ready), 1);
        check(req_line == 1'b0, "R4 line low after frame", int'(req_line), 0);
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        check(cmd_ready == 1'b1, "R10 ready in reset", int'(cmd_ready), 1);
        check(req_line == 1'b0, "R10 line low in reset", int'(req_line), 0);
        check(arb_outstanding == 1'b0, "R10 no outstanding in reset", int'(arb_outstanding), 0);
        rst = 1'b0;
        @(negedge clk);
        check(req_line == 1'b0, "R4 line low when idle", int'(req_line), 0);
    endtask

    task automatic t_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        logic [WR_LEN-1:0] got;
        capture(1'b0, a, d, 1'b0, WR_LEN, got);
        check(got == exp_write(a, d), "R1 write frame", int'(got), int'(exp_write(a, d)));
    endtask

    task automatic t_accel(input logic on);
        logic [WR_LEN-1:0] got;
        capture(1'b1, '0, '0, on, AC_LEN, got);
        check(got == exp_accel(on), "R2 accel frame", int'(got), int'(exp_accel(on)));
    endtask

    task automatic t_busy_ignore;
        logic [WR_LEN-1:0] got;
        logic [WR_LEN-1:0] exp;
        bit quiet;
        exp = exp_write(4'h6, 8'h3A);
        got = '0;
        @(negedge clk);
        cmd_kind = 1'b0; cmd_addr = 4'h6; cmd_data = 8'h3A; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        for (int i = 0; i < WR_LEN; i++) begin
            got[i] = req_line;
            if (i == 2) begin
                cmd_kind = 1'b1; cmd_accel_on = 1'b1; cmd_addr = 4'h9; cmd_data = 8'hC5;
                cmd_valid = 1'b1;
            end
            if (i == 8) cmd_valid = 1'b0;
            @(negedge clk);
        end
        check(got == exp, "R4 offer while busy ignored", int'(got), int'(exp));
        quiet = 1'b1;
        for (int k = 0; k < 4; k++) begin
            if (req_line) quiet = 1'b0;
            @(negedge clk);
        end
        check(quiet, "R4 no frame from ignored offer", int'(quiet), 1);
    endtask

    task automatic t_back_to_back;
        @(negedge clk);
        cmd_kind = 1'b1; cmd_accel_on = 1'b0; cmd_valid = 1'b1;
        repeat (AC_LEN + 1) @(negedge clk);
        check(cmd_ready == 1'b1, "R3 ready in clock after stop", int'(cmd_ready), 1);
        @(negedge clk);
        cmd_valid = 1'b0;
        check(req_line == 1'b1, "R3 next frame starts at once", int'(req_line), 1);
        check(cmd_ready == 1'b0, "R3 ready low for second frame", int'(cmd_ready), 0);
        repeat (AC_LEN + 2) @(negedge clk);
    endtask

    task automatic t_arb_idle;
        ctl_code = 2'b10;
        repeat (3) @(negedge clk);
        ctl_code = 2'b00;
        #1;
        check(arb_allowed == 1'b0, "R5 first idle clock not allowed", int'(arb_allowed), 0);
        @(negedge clk);
        check(arb_allowed == 1'b1, "R5 second idle clock allowed", int'(arb_allowed), 1);
        ctl_code = 2'b01;
        #1;
        check(arb_allowed == 1'b0, "R5 status code not allowed", int'(arb_allowed), 0);
        @(negedge clk);
        ctl_code = 2'b00;
        @(negedge clk);
    endtask

    task automatic t_arb_flow;
        ctl_code = 2'b00;
        repeat (2) @(negedge clk);
        check(arb_allowed == 1'b1, "R5 idle allows", int'(arb_allowed), 1);
        arb_issue = 1'b1;
        @(negedge clk);
        arb_issue = 1'b0;
        check(arb_outstanding == 1'b1, "R7 issue recorded", int'(arb_outstanding), 1);
        check(arb_allowed == 1'b0, "R6 blocked while outstanding", int'(arb_allowed), 0);
        arb_won = 1'b1;
        @(negedge clk);
        arb_won = 1'b0;
        check(arb_outstanding == 1'b0, "R8 won clears", int'(arb_outstanding), 0);
        check(arb_allowed == 1'b1, "R8 reopened after won", int'(arb_allowed), 1);
        arb_issue = 1'b1;
        @(negedge clk);
        arb_issue = 1'b0;
        arb_lost = 1'b1;
        @(negedge clk);
        arb_lost = 1'b0;
        check(arb_outstanding == 1'b0, "R8 lost clears", int'(arb_outstanding), 0);
        ctl_code = 2'b10;
        arb_issue = 1'b1;
        @(negedge clk);
        arb_issue = 1'b0;
        check(arb_outstanding == 1'b0, "R7 issue outside window ignored", int'(arb_outstanding), 0);
        ctl_code = 2'b00;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reg_while_pending;
        logic [WR_LEN-1:0] got;
        ctl_code = 2'b00;
        repeat (2) @(negedge clk);
        arb_issue = 1'b1;
        @(negedge clk);
        arb_issue = 1'b0;
        ctl_code = 2'b10;
        capture(1'b0, 4'hC, 8'h96, 1'b0, WR_LEN, got);
        check(got == exp_write(4'hC, 8'h96), "R9 write while pending", int'(got), int'(exp_write(4'hC, 8'h96)));
        check(arb_outstanding == 1'b1, "R9 pending kept", int'(arb_outstanding), 1);
        arb_won = 1'b1;
        @(negedge clk);
        arb_won = 1'b0;
        ctl_code = 2'b00;
        repeat (2) @(negedge clk);
        cmd_kind = 1'b1; cmd_accel_on = 1'b1; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        @(negedge clk);
        check(arb_allowed == 1'b0, "R6 blocked while frame on line", int'(arb_allowed), 0);
        repeat (AC_LEN + 2) @(negedge clk);
        check(arb_allowed == 1'b1, "R6 reopened after frame", int'(arb_allowed), 1);
    endtask

    task automatic t_reset_mid;
        ctl_code = 2'b00;
        repeat (2) @(negedge clk);
        arb_issue = 1'b1;
        @(negedge clk);
        arb_issue = 1'b0;
        cmd_kind = 1'b0; cmd_addr = 4'hF; cmd_data = 8'hFF; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(req_line == 1'b0, "R10 line low after reset", int'(req_line), 0);
        check(cmd_ready == 1'b1, "R10 ready after reset", int'(cmd_ready), 1);
        check(arb_outstanding == 1'b0, "R10 outstanding cleared", int'(arb_outstanding), 0);
        repeat (3) @(negedge clk);
        check(req_line == 1'b0, "R10 frame abandoned", int'(req_line), 0);
    endtask

    initial begin
        t_reset();
        t_write(4'h0, 8'h00);
        t_write(4'hF, 8'hFF);
        t_write(4'hA, 8'h5C);
        t_write(4'h3, 8'h81);
        t_accel(1'b1);
        t_accel(1'b0);
        t_busy_ignore();
        t_back_to_back();
        t_arb_idle();
        t_arb_flow();
        t_reg_while_pending();
        t_reset_mid();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule